// File: doc/BRIEF.md
# Prioritized Interrupt CPU Interface

This block collects a set of level-sensitive interrupt inputs and presents one interrupt request line to a single processor. Each source carries an 8-bit priority (smaller value means more urgent) and a group bit. A source's pending state follows its input level. Its active state is set when the processor acknowledges it and cleared when the processor deactivates it. Of all sources that are pending and not active, the most urgent one is signalled. It must also pass the priority mask and preempt the current running priority.

The processor uses a small register bus. Each access carries a non-secure attribute. Reading the acknowledge register returns the chosen source ID and makes that source active. A priority-drop write restores the previous running priority from a small stack of active priorities. A deactivate write clears the active state of one source. Secure and non-secure accesses see separate binary-point registers, which set how many low priority bits are ignored for preemption. A common-binary-point control bit changes how the non-secure view behaves.

Top module: `prio_irq_cpuif`

## Requirements
- R1: After reset, `irq_o` is low, the mask register reads 0xFF, both binary points read 0, the running-priority register (address 6) reads 0xFF and the acknowledge register (address 3) returns the spurious ID 1023.
- R2: Among eligible sources, `irq_o` signals the one with the smallest priority value, with ties going to the lowest ID. An acknowledge read returns that ID in bits [9:0].
- R3: A source is eligible only if its priority (written at address 8+ID, bits [7:0]) is strictly less than the mask (address 1, bits [7:0]).
- R4: A source is eligible only if its group priority is strictly less than the running priority. The group priority is the priority with its low (bp+1) bits cleared, where bp is the effective binary point.
- R5: An acknowledge read with nothing eligible returns 1023 and changes no state. Otherwise it makes the returned source active. The source stays pending while its input stays asserted.
- R6: A source that is active, whether pending or not, is never signalled. Right after an acknowledge, `irq_o` falls unless another source can preempt.
- R7: A write to address 4 pops the active-priority stack and restores the previous running priority. The source stays active and unsignalled until it is deactivated.
- R8: A write of an ID to address 5 clears that source's active state. An ID that is not active has no effect.
- R9: The running-priority register reads 0xFF when no priority is on the stack. Otherwise it reads the group priority on top of the stack.
- R10: The binary point is at address 2, bits [2:0]. Secure accesses use the Secure value. When control bit 0 (address 0) is 1, a non-secure read returns the Secure value plus one, saturated at 7, and a non-secure write is ignored. When the bit is 0, non-secure accesses use the non-secure value.
- R11: When control bit 0 is 0, a group 1 source (bit ID of the group register at address 16) uses the non-secure binary point plus one, saturated at 7. When the bit is 1 it uses the Secure binary point, and group 0 sources always do.
- R12: Reads of unused addresses return zero. Writes to them change nothing.
- R13: When the active-priority stack holds STACK_DEPTH entries, no source is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NUM_SRC | Level interrupt inputs |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_ns | input | 1 | Access is non-secure |
| bus_rdata | output | DATA_W | Read data, valid the cycle after the strobe |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The assertions check on every cycle that:
- an acknowledge only ever activates a pending, inactive source;
- an active source stays active until its own deactivate;
- the stack never overflows or underflows, and a push always lowers the running priority;
- unused addresses and the idle running priority read back correctly;
- a non-secure binary-point write under the common bit leaves the non-secure value unchanged.

Only the bench's scenarios can show the rest: which source wins among many, the tie order, the restore order after nested drops, and the exact effect of the non-secure "plus one" on preemption. To cover these, the bench sweeps every input pattern of eight sources and runs targeted nesting and binary-point cases.

// File: rtl/prio_irq_pkg.sv
// Package: shared constants and helpers for the prioritized interrupt CPU interface.
// Assumes 8-bit priorities where a smaller value is more urgent.
package prio_irq_pkg;
    localparam int PRIO_W      = 8;
    localparam int RP_W        = PRIO_W + 1;
    localparam int ID_W        = 10;
    localparam int BP_W        = 3;
    localparam int SPURIOUS_ID = 1023;
    localparam logic [RP_W-1:0] IDLE_RP = 9'h100;

    // Register addresses
    localparam int REG_CTRL   = 0;
    localparam int REG_PMASK  = 1;
    localparam int REG_BINPT  = 2;
    localparam int REG_ACK    = 3;
    localparam int REG_DROP   = 4;
    localparam int REG_DEACT  = 5;
    localparam int REG_RUNPRI = 6;
    localparam int REG_PRIO0  = 8;
    localparam int REG_GROUP  = 16;

    // Priority with its low (bp+1) bits cleared
    function automatic logic [PRIO_W-1:0] group_prio(input logic [PRIO_W-1:0] prio,
                                                     input logic [BP_W-1:0] bp);
        logic [PRIO_W:0] keep;
        keep = {(PRIO_W+1){1'b1}} << ({1'b0, bp} + 4'd1);
        return prio & keep[PRIO_W-1:0];
    endfunction

    // Binary point plus one, saturated at 7
    function automatic logic [BP_W-1:0] bp_inc_sat(input logic [BP_W-1:0] bp);
        return (bp == 3'd7) ? 3'd7 : bp + 3'd1;
    endfunction
endpackage

// File: rtl/prio_irq_src_state.sv
// Module: per-source pending and active state.
// Pending mirrors the registered input level. Active is set by acknowledge and cleared by deactivate.
// Assumes an acknowledge and a deactivate never target the same source in one cycle.
module prio_irq_src_state
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               ack_en_i,
    input  logic [ID_W-1:0]    ack_id_i,
    input  logic               deact_en_i,
    input  logic [ID_W-1:0]    deact_id_i,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] active_o
);
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] active_q;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic hit_ack;
        logic hit_deact;
        assign hit_ack   = ack_en_i   && (ack_id_i   == ID_W'(i));
        assign hit_deact = deact_en_i && (deact_id_i == ID_W'(i));

        // Register the level input as the pending state
        always_ff @(posedge clk) begin
            if (!rst_n) pend_q[i] <= 1'b0;
            else        pend_q[i] <= src_i[i];
        end

        // Set active on acknowledge and clear it on deactivate
        always_ff @(posedge clk) begin
            if (!rst_n)         active_q[i] <= 1'b0;
            else if (hit_ack)   active_q[i] <= 1'b1;
            else if (hit_deact) active_q[i] <= 1'b0;
        end

        AST_ACK_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            hit_ack |-> (pend_q[i] && !active_q[i])); // R6
        AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (active_q[i] && !hit_deact) |=> active_q[i]); // R8
    end

    assign pend_o   = pend_q;
    assign active_o = active_q;
endmodule

// File: rtl/prio_irq_select.sv
// Module: combinational choice of the source to signal.
// A source is eligible when it is pending, inactive, below the mask and preempts the running priority, and the stack is not full.
// Picks the smallest priority value; ties go to the lowest ID.
module prio_irq_select
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic [NUM_SRC-1:0]             pend_i,
    input  logic [NUM_SRC-1:0]             active_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
    input  logic [NUM_SRC-1:0]             group_i,
    input  logic [BP_W-1:0]                bp_s_i,
    input  logic [BP_W-1:0]                bp_ns_i,
    input  logic                           common_i,
    input  logic [PRIO_W-1:0]              pmask_i,
    input  logic [RP_W-1:0]                running_i,
    input  logic                           full_i,
    output logic                           hit_o,
    output logic [ID_W-1:0]                sel_id_o,
    output logic [PRIO_W-1:0]              sel_gprio_o
);
    logic [NUM_SRC-1:0]             elig;
    logic [NUM_SRC-1:0][PRIO_W-1:0] gprio;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
        logic [BP_W-1:0] bp_eff;
        // Effective binary point for this source's group
        assign bp_eff   = (group_i[i] && !common_i) ? bp_inc_sat(bp_ns_i) : bp_s_i;
        assign gprio[i] = group_prio(prio_i[i], bp_eff);
        assign elig[i]  = pend_i[i] && !active_i[i] && (prio_i[i] < pmask_i)
                       && ({1'b0, gprio[i]} < running_i) && !full_i;
    end

    // Scan for the most urgent eligible source; a strict compare keeps the lower ID on ties
    always_comb begin
        logic [PRIO_W-1:0] best_p;
        hit_o       = 1'b0;
        best_p      = '1;
        sel_id_o    = ID_W'(SPURIOUS_ID);
        sel_gprio_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] && (!hit_o || prio_i[i] < best_p)) begin
                hit_o       = 1'b1;
                best_p      = prio_i[i];
                sel_id_o    = ID_W'(i);
                sel_gprio_o = gprio[i];
            end
        end
    end
endmodule

// File: rtl/prio_irq_stack.sv
// Module: stack of the group priorities of acknowledged interrupts.
// The top entry is the running priority, and an empty stack gives the idle value 0x100.
// Assumes the caller never pushes when full and never pops when empty.
module prio_irq_stack
    import prio_irq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [PRIO_W-1:0] push_prio_i,
    input  logic              pop_i,
    output logic [RP_W-1:0]   running_o,
    output logic              full_o,
    output logic              empty_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [PRIO_W-1:0] slot_q [DEPTH];

    // Track how many entries the stack holds
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (push_i && !full_o)  cnt_q <= cnt_q + 1'b1;
        else if (pop_i && !empty_o)  cnt_q <= cnt_q - 1'b1;
    end

    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        // Store the pushed priority in the next free slot
        always_ff @(posedge clk) begin
            if (!rst_n)                                          slot_q[k] <= '0;
            else if (push_i && !full_o && cnt_q == CNT_W'(k))    slot_q[k] <= push_prio_i;
        end
    end

    // The top slot, or the idle value, is the running priority
    always_comb begin
        running_o = IDLE_RP;
        for (int k = 0; k < DEPTH; k++) begin
            if (cnt_q == CNT_W'(k + 1)) running_o = {1'b0, slot_q[k]};
        end
    end

    assign full_o  = (cnt_q == CNT_W'(DEPTH));
    assign empty_o = (cnt_q == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o); // R13
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o); // R7
    AST_PUSH_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (running_o < $past(running_o))); // R4
endmodule

// File: rtl/prio_irq_cpuif.sv
// Module: top of the prioritized interrupt CPU interface.
// It decodes the register bus, holds configuration and drives the interrupt line from registered state.
// Assumes NUM_SRC <= 8, so that the priority registers fit at addresses 8..15, and that the bus
// never asserts read and write in the same cycle.
module prio_irq_cpuif
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC     = 8,
    parameter int STACK_DEPTH = 4,
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_ns,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_o
);
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
    logic [NUM_SRC-1:0] group_q;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] active;
    logic [PRIO_W-1:0]  pmask_q;
    logic [BP_W-1:0]    bp_s_q;
    logic [BP_W-1:0]    bp_ns_q;
    logic               common_q;
    logic [DATA_W-1:0]  rdata_q;
    logic [DATA_W-1:0]  rd_val;
    logic               hit;
    logic [ID_W-1:0]    sel_id;
    logic [PRIO_W-1:0]  sel_gprio;
    logic [RP_W-1:0]    running;
    logic               full;
    logic               empty;
    logic               ack_en;
    logic               drop_en;
    logic               deact_en;
    logic               addr_known;
    logic               wdata_unused;

    assign wdata_unused = ^bus_wdata;

    function automatic logic at(input logic [ADDR_W-1:0] a, input int r);
        return a == ADDR_W'(r);
    endfunction

    assign ack_en   = bus_rd && at(bus_addr, REG_ACK) && hit;
    assign drop_en  = bus_wr && at(bus_addr, REG_DROP) && !empty;
    assign deact_en = bus_wr && at(bus_addr, REG_DEACT);

    prio_irq_src_state #(.NUM_SRC(NUM_SRC)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src_i),
        .ack_en_i   (ack_en),
        .ack_id_i   (sel_id),
        .deact_en_i (deact_en),
        .deact_id_i (bus_wdata[ID_W-1:0]),
        .pend_o     (pend),
        .active_o   (active)
    );

    prio_irq_select #(.NUM_SRC(NUM_SRC)) u_select (
        .pend_i      (pend),
        .active_i    (active),
        .prio_i      (prio_q),
        .group_i     (group_q),
        .bp_s_i      (bp_s_q),
        .bp_ns_i     (bp_ns_q),
        .common_i    (common_q),
        .pmask_i     (pmask_q),
        .running_i   (running),
        .full_i      (full),
        .hit_o       (hit),
        .sel_id_o    (sel_id),
        .sel_gprio_o (sel_gprio)
    );

    prio_irq_stack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (ack_en),
        .push_prio_i (sel_gprio),
        .pop_i       (drop_en),
        .running_o   (running),
        .full_o      (full),
        .empty_o     (empty)
    );

    // Control, mask and group registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            common_q <= 1'b0;
            pmask_q  <= '1;
            group_q  <= '0;
        end else if (bus_wr) begin
            if (at(bus_addr, REG_CTRL))  common_q <= bus_wdata[0];
            if (at(bus_addr, REG_PMASK)) pmask_q  <= bus_wdata[PRIO_W-1:0];
            if (at(bus_addr, REG_GROUP)) group_q  <= bus_wdata[NUM_SRC-1:0];
        end
    end

    // Binary-point registers, with the non-secure write locked under the common bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bp_s_q  <= '0;
            bp_ns_q <= '0;
        end else if (bus_wr && at(bus_addr, REG_BINPT)) begin
            if (!bus_ns)        bp_s_q  <= bus_wdata[BP_W-1:0];
            else if (!common_q) bp_ns_q <= bus_wdata[BP_W-1:0];
        end
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_prio
        // Per-source priority register
        always_ff @(posedge clk) begin
            if (!rst_n)                                    prio_q[g] <= '0;
            else if (bus_wr && at(bus_addr, REG_PRIO0 + g)) prio_q[g] <= bus_wdata[PRIO_W-1:0];
        end
    end

    // Read multiplexer; any address not listed reads zero
    always_comb begin
        rd_val     = '0;
        addr_known = 1'b1;
        if (at(bus_addr, REG_CTRL))        rd_val = DATA_W'(common_q);
        else if (at(bus_addr, REG_PMASK))  rd_val = DATA_W'(pmask_q);
        else if (at(bus_addr, REG_BINPT))  rd_val = DATA_W'(!bus_ns ? bp_s_q :
                                                    (common_q ? bp_inc_sat(bp_s_q) : bp_ns_q));
        else if (at(bus_addr, REG_ACK))    rd_val = DATA_W'(hit ? sel_id : ID_W'(SPURIOUS_ID));
        else if (at(bus_addr, REG_RUNPRI)) rd_val = DATA_W'(running[PRIO_W] ? {PRIO_W{1'b1}}
                                                                            : running[PRIO_W-1:0]);
        else if (at(bus_addr, REG_GROUP))  rd_val = DATA_W'(group_q);
        else if (at(bus_addr, REG_DROP) || at(bus_addr, REG_DEACT)) rd_val = '0;
        else begin
            addr_known = 1'b0;
            for (int i = 0; i < NUM_SRC; i++) begin
                if (at(bus_addr, REG_PRIO0 + i)) begin
                    rd_val     = DATA_W'(prio_q[i]);
                    addr_known = 1'b1;
                end
            end
        end
    end

    // Registered read data, valid the cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_val;
        else             rdata_q <= '0;
    end

    assign bus_rdata = rdata_q;
    assign irq_o     = hit;

    AST_RAZ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !addr_known) |=> (bus_rdata == '0)); // R12
    AST_IDLE_RUNPRI: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && at(bus_addr, REG_RUNPRI) && empty) |=> (bus_rdata == DATA_W'(8'hFF))); // R9
    AST_NS_BP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_ns && common_q && at(bus_addr, REG_BINPT)) |=> $stable(bp_ns_q)); // R10
    AST_SPURIOUS_ID: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && at(bus_addr, REG_ACK) && !irq_o) |=> (bus_rdata == DATA_W'(SPURIOUS_ID))); // R5
    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr)); // R12
endmodule

// File: tb/prio_irq_cpuif_bench.sv
// Bench: sweeps every input pattern of eight sources, then runs targeted mask, nesting, stack and binary-point cases.
module prio_irq_cpuif_bench;
    localparam int NSRC = 8;
    localparam int A_CTRL = 0, A_PMASK = 1, A_BINPT = 2, A_ACK = 3, A_DROP = 4,
                   A_DEACT = 5, A_RUNPRI = 6, A_PRIO0 = 8, A_GROUP = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src = '0;
    logic            bus_rd = 1'b0, bus_wr = 1'b0, bus_ns = 1'b0;
    logic [5:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            irq;
    int              errors = 0;
    int              checks = 0;

    always #5 clk = ~clk;

    prio_irq_cpuif u_prio_irq_cpuif (
        .clk (clk), .rst_n (rst_n), .src_i (src), .bus_rd (bus_rd), .bus_wr (bus_wr),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_ns (bus_ns),
        .bus_rdata (bus_rdata), .irq_o (irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d, input logic ns);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = 32'(d); bus_ns = ns;
        @(negedge clk);
        bus_wr = 1'b0; bus_ns = 1'b0;
    endtask

    task automatic rd(input int a, input logic ns, output int r);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 6'(a); bus_ns = ns;
        @(negedge clk);
        r = int'(bus_rdata);
        bus_rd = 1'b0; bus_ns = 1'b0;
    endtask

    task automatic set_src(input logic [NSRC-1:0] v);
        @(negedge clk);
        src = v;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; src = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    function automatic int sweep_prio(input int i);
        return 16 * (((i * 3) % 5) + 1);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int r;
        do_reset();
        // R1 reset state
        chk("R1 irq", int'(irq), 0);
        rd(A_RUNPRI, 1'b0, r); chk("R1 runpri", r, 'hFF);
        rd(A_PMASK, 1'b0, r);  chk("R1 pmask", r, 'hFF);
        rd(A_BINPT, 1'b0, r);  chk("R1 bp", r, 0);
        rd(A_ACK, 1'b0, r);    chk("R1 spurious", r, 1023);
        chk("R5 no state change", int'(irq), 0);

        // R2/R6/R7/R8/R9 sweep of all input patterns
        for (int i = 0; i < NSRC; i++) wr(A_PRIO0 + i, sweep_prio(i), 1'b0);
        for (int p = 1; p < 256; p++) begin
            int best, cnt;
            best = -1; cnt = 0;
            for (int i = 0; i < NSRC; i++) begin
                if (p[i]) begin
                    cnt++;
                    if (best < 0 || sweep_prio(i) < sweep_prio(best)) best = i;
                end
            end
            set_src(NSRC'(p));
            chk("R2 irq raised", int'(irq), 1);
            rd(A_ACK, 1'b0, r);        chk("R2 winner id", r, best);
            chk("R6 irq after ack", int'(irq), 0);
            rd(A_RUNPRI, 1'b0, r);     chk("R9 runpri active", r, sweep_prio(best));
            wr(A_DROP, 0, 1'b0);
            chk("R7 active not resignalled", int'(irq), (cnt > 1) ? 1 : 0);
            wr(A_DEACT, best, 1'b0);
            chk("R8 deactivated resignals", int'(irq), 1);
            set_src('0);
            rd(A_RUNPRI, 1'b0, r);     chk("R9 idle", r, 'hFF);
        end

        // R3 priority mask boundary
        do_reset();
        wr(A_PRIO0 + 3, 'h50, 1'b0);
        wr(A_PMASK, 'h50, 1'b0);
        set_src(8'h08);
        chk("R3 equal mask blocks", int'(irq), 0);
        wr(A_PMASK, 'h51, 1'b0);
        chk("R3 above mask passes", int'(irq), 1);

        // R4/R6/R7/R8 nesting
        do_reset();
        wr(A_PRIO0 + 0, 'h40, 1'b0);
        wr(A_PRIO0 + 1, 'h20, 1'b0);
        wr(A_PRIO0 + 2, 'h21, 1'b0);
        set_src(8'h01);
        rd(A_ACK, 1'b0, r);    chk("R5 ack s0", r, 0);
        set_src(8'h03);
        chk("R4 preempt", int'(irq), 1);
        rd(A_ACK, 1'b0, r);    chk("R4 ack s1", r, 1);
        rd(A_RUNPRI, 1'b0, r); chk("R9 runpri 0x20", r, 'h20);
        set_src(8'h07);
        chk("R4 equal group no preempt", int'(irq), 0);
        wr(A_DROP, 0, 1'b0);
        rd(A_RUNPRI, 1'b0, r); chk("R7 restored 0x40", r, 'h40);
        chk("R4 s2 now preempts", int'(irq), 1);
        rd(A_ACK, 1'b0, r);    chk("R4 ack s2", r, 2);
        wr(A_DEACT, 3, 1'b0);
        rd(A_RUNPRI, 1'b0, r); chk("R8 inactive deact runpri", r, 'h20);
        chk("R8 inactive deact irq", int'(irq), 0);
        wr(A_DROP, 0, 1'b0);
        wr(A_DROP, 0, 1'b0);
        rd(A_RUNPRI, 1'b0, r); chk("R7 all dropped", r, 'hFF);
        chk("R6 active and pending silent", int'(irq), 0);
        wr(A_DEACT, 1, 1'b0);
        chk("R8 deact s1", int'(irq), 1);
        rd(A_ACK, 1'b0, r);    chk("R8 reack s1", r, 1);

        // R13 stack full
        do_reset();
        for (int k = 0; k < 5; k++) wr(A_PRIO0 + k, 'h80 - 'h10 * k, 1'b0);
        for (int k = 0; k < 5; k++) begin
            set_src(NSRC'((1 << (k + 1)) - 1));
            if (k < 4) begin
                rd(A_ACK, 1'b0, r); chk("R13 nested ack", r, k);
            end else begin
                chk("R13 full blocks", int'(irq), 0);
            end
        end
        wr(A_DROP, 0, 1'b0);
        chk("R13 room again", int'(irq), 1);

        // R10 non-secure binary point view
        do_reset();
        wr(A_CTRL, 1, 1'b0);
        wr(A_BINPT, 3, 1'b0);
        rd(A_BINPT, 1'b1, r);  chk("R10 ns plus one", r, 4);
        wr(A_BINPT, 7, 1'b0);
        rd(A_BINPT, 1'b1, r);  chk("R10 ns saturate", r, 7);
        wr(A_BINPT, 1, 1'b1);
        rd(A_BINPT, 1'b0, r);  chk("R10 secure kept", r, 7);
        wr(A_CTRL, 0, 1'b0);
        rd(A_BINPT, 1'b1, r);  chk("R10 ns write ignored", r, 0);
        wr(A_BINPT, 2, 1'b1);
        rd(A_BINPT, 1'b1, r);  chk("R10 ns own value", r, 2);
        rd(A_BINPT, 1'b0, r);  chk("R10 secure untouched", r, 7);

        // R11 group 1 preemption uses the non-secure binary point plus one
        do_reset();
        wr(A_PRIO0 + 0, 'h28, 1'b0);
        wr(A_PRIO0 + 1, 'h2F, 1'b0);
        wr(A_GROUP, 2, 1'b0);
        wr(A_CTRL, 1, 1'b0);
        set_src(8'h01);
        rd(A_ACK, 1'b0, r);    chk("R11 ack s0", r, 0);
        set_src(8'h03);
        chk("R11 common uses secure bp", int'(irq), 0);
        wr(A_CTRL, 0, 1'b0);
        wr(A_BINPT, 2, 1'b1);
        chk("R11 ns bp plus one preempts", int'(irq), 1);
        wr(A_BINPT, 1, 1'b1);
        chk("R11 smaller ns bp no preempt", int'(irq), 0);

        // R12 reserved addresses
        do_reset();
        wr(A_PMASK, 'h33, 1'b0);
        wr(7, 'hFFFF, 1'b0);
        wr('h11, 'hFF, 1'b0);
        rd(7, 1'b0, r);        chk("R12 read 7", r, 0);
        rd('h3F, 1'b1, r);     chk("R12 read 0x3F", r, 0);
        rd(A_PMASK, 1'b0, r);  chk("R12 pmask kept", r, 'h33);
        rd(A_GROUP, 1'b0, r);  chk("R12 group kept", r, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule